// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width-modulated output channel with a small write/read register bank. A mode register picks the count clock, the counting shape (sawtooth or triangle) and the level the output rests at. A period register sets where the counter turns around, and a duty register sets how long the output sits at its active level in each period. The counter itself can be read back.

The count clock comes from one of three sources: the system clock through a power-of-two prescaler, or one of two externally generated single-cycle tick strobes. Software changes the period or the duty while the channel runs by writing a shared update register. The value written there waits in a holding buffer and is copied into its target only when the counter next returns to zero, so a period never mixes old and new settings. A one-cycle interrupt marks each return to zero, and software can use it to pace its updates. The channel enable input stops and restarts the channel without losing its configuration.

Top module: `pwm_channel`

## Requirements
- R1: The registers sit at byte addresses 0x00 (mode), 0x04 (duty), 0x08 (period), 0x0C (counter) and 0x10 (update buffer), and all of them read back combinationally on rdData. In the mode register, bit 10 picks the update target, bit 9 picks idle-high, bit 8 picks center alignment and bits 3:0 pick the clock. All other mode bits read as zero, and reset clears every register.
- R2: A clock selection of 0 to 10 advances the counter once every 2^sel system clock cycles. Selection 0xB advances it only on extATick pulses and selection 0xC only on extBTick pulses. Selections 0xD to 0xF never advance it.
- R3: In left-aligned mode (bit 8 clear), the counter steps 0,1,...,period and then wraps to 0, so one period lasts period+1 counter steps.
- R4: In center-aligned mode (bit 8 set), the counter steps 0 up to period and back down to 1, and then returns to 0, so one period lasts 2*period steps. A period of 0 or 1 wraps straight from the top back to 0.
- R5: While enabled, the output is at its active level whenever counter < duty, and at the idle level otherwise. The active level is the opposite of the idle level. With bit 9 set the idle level is 1, and with bit 9 clear it is 0.
- R6: While chanEn is low, pwmOut sits at the idle level and the counter is held at zero and reads as zero. When chanEn rises again, the channel runs with its stored configuration.
- R7: A write to the update buffer is held until the next boundary, where the counter returns to 0, and only then copied into the period if mode bit 10 was set at write time, or into the duty if it was clear. Until that boundary, the target register reads its old value.
- R8: Direct writes to duty or period take effect at once while chanEn is low. While chanEn is high they are ignored.
- R9: irq is a one-cycle pulse, high in the first cycle in which the counter is 0 after a boundary. It does not pulse while the channel is disabled.
- R10: The counter is read-only, and a write to address 0x0C changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel run enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address for write and read |
| wrData | input | 20 | Write data |
| rdData | output | 20 | Read data for addr |
| extATick | input | 1 | External clock A tick strobe |
| extBTick | input | 1 | External clock B tick strobe |
| pwmOut | output | 1 | PWM output |
| irq | output | 1 | Once-per-period interrupt pulse |

## Verification
A counter stuck off its intended sequence shows up within one period in two ways: the spacing between irq pulses changes, and the number of active cycles in each period changes. Both are measured as cycle counts against the formulas in R3 to R5. A holding buffer that commits too early is visible at once on rdData, because the target register is read back straight after the update write. A buffer that commits late or to the wrong target shows up at the first boundary after the write. A stale counter or prescaler after a disable is seen the first time the counter is read back after re-enabling.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int CLK_SEL_W = 4;
  localparam logic [CLK_SEL_W-1:0] SEL_EXT_A = 4'hB;
  localparam logic [CLK_SEL_W-1:0] SEL_EXT_B = 4'hC;

  localparam logic [4:0] ADR_MODE   = 5'h00;
  localparam logic [4:0] ADR_DUTY   = 5'h04;
  localparam logic [4:0] ADR_PERIOD = 5'h08;
  localparam logic [4:0] ADR_COUNT  = 5'h0C;
  localparam logic [4:0] ADR_UPDATE = 5'h10;

  localparam int BIT_UPD_PERIOD = 10;
  localparam int BIT_IDLE_HIGH  = 9;
  localparam int BIT_CENTER     = 8;

  typedef struct packed {
    logic                 updPeriod;
    logic                 idleHigh;
    logic                 center;
    logic [CLK_SEL_W-1:0] clkSel;
  } modeCfgT;

  typedef struct packed {
    logic tick;
    logic halt;
  } pwmStrobeT;
endpackage

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrEn,
  input  logic [4:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             extATick,
  input  logic             extBTick,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             wrap,
  output pwmStrobeT        strb,
  output modeCfgT          modeCfg,
  output logic [CNT_W-1:0] dutyReg,
  output logic [CNT_W-1:0] periodReg,
  output logic [CNT_W-1:0] rdData
);
  localparam int PRE_W = PRE_MAX;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             preHit;
  logic [CNT_W-1:0] updBuf;
  logic             updPending;
  logic             updTgtPeriod;
  logic             wrMode, wrDuty, wrPeriod, wrUpdate;

  assign wrMode   = wrEn && (addr == ADR_MODE);
  assign wrDuty   = wrEn && (addr == ADR_DUTY);
  assign wrPeriod = wrEn && (addr == ADR_PERIOD);
  assign wrUpdate = wrEn && (addr == ADR_UPDATE);

  // prescaler: preLimit = 2^sel - 1
  assign preLimit = (PRE_W'(1) << modeCfg.clkSel) - PRE_W'(1);
  assign preHit   = (preCnt == preLimit);

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn || (32'(modeCfg.clkSel) > PRE_MAX)) preCnt <= '0;
    else if (preHit)                                        preCnt <= '0;
    else                                                    preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    strb.halt = !chanEn;
    strb.tick = 1'b0;
    if (chanEn) begin
      if (32'(modeCfg.clkSel) <= PRE_MAX) strb.tick = preHit;
      else if (modeCfg.clkSel == SEL_EXT_A) strb.tick = extATick;
      else if (modeCfg.clkSel == SEL_EXT_B) strb.tick = extBTick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeCfg <= '0;
    else if (wrMode) begin
      modeCfg.updPeriod <= wrData[BIT_UPD_PERIOD];
      modeCfg.idleHigh  <= wrData[BIT_IDLE_HIGH];
      modeCfg.center    <= wrData[BIT_CENTER];
      modeCfg.clkSel    <= wrData[CLK_SEL_W-1:0];
    end
  end

  // duty/period: direct writes while stopped, buffered commit at boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyReg   <= '0;
      periodReg <= '0;
    end else begin
      if (wrap && updPending) begin
        if (updTgtPeriod) periodReg <= updBuf;
        else              dutyReg   <= updBuf;
      end
      if (wrDuty && !chanEn)   dutyReg   <= wrData;
      if (wrPeriod && !chanEn) periodReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updBuf       <= '0;
      updPending   <= 1'b0;
      updTgtPeriod <= 1'b0;
    end else begin
      if (wrap && updPending) updPending <= 1'b0;
      if (wrUpdate) begin
        updBuf       <= wrData;
        updPending   <= 1'b1;
        updTgtPeriod <= modeCfg.updPeriod;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADR_MODE: begin
        rdData[BIT_UPD_PERIOD]  = modeCfg.updPeriod;
        rdData[BIT_IDLE_HIGH]   = modeCfg.idleHigh;
        rdData[BIT_CENTER]      = modeCfg.center;
        rdData[CLK_SEL_W-1:0]   = modeCfg.clkSel;
      end
      ADR_DUTY:   rdData = dutyReg;
      ADR_PERIOD: rdData = periodReg;
      ADR_COUNT:  rdData = cntVal;
      ADR_UPDATE: rdData = updBuf;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_datapath.sv
`timescale 1ns/1ps
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobeT        strb,
  input  logic             center,
  input  logic             idleHigh,
  input  logic [CNT_W-1:0] periodReg,
  input  logic [CNT_W-1:0] dutyReg,
  output logic [CNT_W-1:0] cntVal,
  output logic             wrap,
  output logic             irq,
  output logic             pwmOut
);
  logic             countDown;
  logic [CNT_W-1:0] nextCnt;
  logic             nextDown;
  logic             active;

  always_comb begin
    nextCnt  = cntVal;
    nextDown = countDown;
    wrap     = 1'b0;
    if (strb.halt) begin
      nextCnt  = '0;
      nextDown = 1'b0;
    end else if (strb.tick) begin
      if (!center) begin
        if (cntVal >= periodReg) begin
          nextCnt = '0;
          wrap    = 1'b1;
        end else begin
          nextCnt = cntVal + CNT_W'(1);
        end
      end else if (!countDown) begin
        if (cntVal >= periodReg) begin
          if (periodReg <= CNT_W'(1)) begin
            nextCnt = '0;
            wrap    = 1'b1;
          end else begin
            nextCnt  = cntVal - CNT_W'(1);
            nextDown = 1'b1;
          end
        end else begin
          nextCnt = cntVal + CNT_W'(1);
        end
      end else begin
        if (cntVal <= CNT_W'(1)) begin
          nextCnt  = '0;
          nextDown = 1'b0;
          wrap     = 1'b1;
        end else begin
          nextCnt = cntVal - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      countDown <= 1'b0;
      irq       <= 1'b0;
    end else begin
      cntVal    <= nextCnt;
      countDown <= nextDown;
      irq       <= wrap;
    end
  end

  assign active = !strb.halt && (cntVal < dutyReg);
  assign pwmOut = active ? !idleHigh : idleHigh;
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrEn,
  input  logic [4:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             extATick,
  input  logic             extBTick,
  output logic             pwmOut,
  output logic             irq
);
  pwmStrobeT        strb;
  modeCfgT          modeCfg;
  logic [CNT_W-1:0] dutyReg;
  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] cntVal;
  logic             wrap;

  pwm_ctrl #(.CNT_W(CNT_W), .PRE_MAX(PRE_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .extATick(extATick), .extBTick(extBTick),
    .cntVal(cntVal), .wrap(wrap), .strb(strb), .modeCfg(modeCfg),
    .dutyReg(dutyReg), .periodReg(periodReg), .rdData(rdData)
  );

  pwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .center(modeCfg.center),
    .idleHigh(modeCfg.idleHigh), .periodReg(periodReg), .dutyReg(dutyReg),
    .cntVal(cntVal), .wrap(wrap), .irq(irq), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_channel_chk.sv
`timescale 1ns/1ps
module pwm_channel_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             pwmOut,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] duty,
  input logic             idleHigh
);
  logic started;
  always_ff @(posedge clk) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= period);

  p_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && cnt < duty) |-> (pwmOut != idleHigh));

  p_idle_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> (pwmOut == idleHigh));

  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (cnt == '0));

  p_period_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(chanEn) && period != $past(period)) |-> irq);

  p_duty_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(chanEn) && duty != $past(duty)) |-> irq);

  p_irq_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (cnt == '0));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !irq);
endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .pwmOut(pwmOut), .irq(irq),
  .cnt(cntVal), .period(periodReg), .duty(dutyReg),
  .idleHigh(modeCfg.idleHigh)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;
  localparam int W = 20;
  localparam int NV = 8;
  // {mode, period, duty, expected cycles per period, expected active-high cycles}
  localparam int VEC [NV][5] = '{
    '{32'h000, 9, 3, 10, 3},   // left
    '{32'h000, 9, 0, 10, 0},   // left, duty zero
    '{32'h000, 9, 9, 10, 9},   // left, duty = period
    '{32'h200, 4, 2, 5,  3},   // left, idle high
    '{32'h100, 5, 2, 10, 3},   // center
    '{32'h300, 5, 5, 10, 1},   // center, idle high
    '{32'h000, 0, 0, 1,  0},   // left, period zero
    '{32'h002, 3, 1, 16, 4}    // left, prescale /4
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic extATick = 1'b0;
  logic extBTick = 1'b0;
  logic pwmOut;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_channel u0 (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .extATick(extATick),
    .extBTick(extBTick), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output int d);
    addr = a;
    #0.5;
    d = int'(rdData);
  endtask

  task automatic waitIrq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  // from one irq to the next: cycles and cycles with pwmOut high
  task automatic measure(output int len, output int hi);
    bit ok;
    len = 0; hi = 0;
    waitIrq(ok);
    if (!ok) return;
    do begin
      if (pwmOut) hi++;
      len++;
      @(negedge clk);
    end while (!irq && len < 4000);
  endtask

  task automatic setup(input int mode, input int per, input int dty);
    @(negedge clk) chanEn = 1'b0;
    wrReg(5'h00, mode);
    wrReg(5'h08, per);
    wrReg(5'h04, dty);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int v, len, hi;
    bit ok;
    repeat (3) @(negedge clk);
    // reset state (R1, R6, R9)
    rdReg(5'h00, v); chk("R1 reset mode", v, 0);
    rdReg(5'h04, v); chk("R1 reset duty", v, 0);
    rdReg(5'h08, v); chk("R1 reset period", v, 0);
    chk("R6 reset output idle", int'(pwmOut), 0);
    chk("R9 reset irq", int'(irq), 0);
    rstN = 1'b1;

    // mode readback, bits outside the fields read zero (R1)
    wrReg(5'h00, 32'hFFFFF);
    rdReg(5'h00, v); chk("R1 mode field readback", v, 32'h70F);

    // table of period/duty shapes (R2, R3, R4, R5)
    for (int r = 0; r < NV; r++) begin
      setup(VEC[r][0], VEC[r][1], VEC[r][2]);
      @(negedge clk) chanEn = 1'b1;
      measure(len, hi);
      chk($sformatf("R3/R4 period length row %0d", r), len, VEC[r][3]);
      chk($sformatf("R5 active cycles row %0d", r), hi, VEC[r][4]);
    end

    // counter readback after re-enable (R1, R6)
    setup(0, 9, 3);
    @(negedge clk) chanEn = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(5'h0C, v); chk("R1 counter readback", v, 4);

    // deferred duty update (R7)
    waitIrq(ok);
    wrReg(5'h10, 6);
    rdReg(5'h04, v); chk("R7 duty unchanged before boundary", v, 3);
    rdReg(5'h10, v); chk("R1 update buffer readback", v, 6);
    waitIrq(ok);
    rdReg(5'h04, v); chk("R7 duty committed at boundary", v, 6);
    measure(len, hi); chk("R7 new duty active cycles", hi, 6);

    // deferred period update (R7)
    wrReg(5'h00, 32'h400);
    wrReg(5'h10, 4);
    rdReg(5'h08, v); chk("R7 period unchanged before boundary", v, 9);
    measure(len, hi); chk("R7 new period length", len, 5);

    // direct write ignored while running (R8)
    wrReg(5'h04, 1);
    rdReg(5'h04, v); chk("R8 duty write ignored while enabled", v, 6);
    wrReg(5'h08, 7);
    rdReg(5'h08, v); chk("R8 period write ignored while enabled", v, 4);

    // disable (R6), direct write while stopped (R8), counter read-only (R10)
    @(negedge clk) chanEn = 1'b0;
    @(negedge clk);
    chk("R6 output idle when disabled", int'(pwmOut), 0);
    rdReg(5'h0C, v); chk("R6 counter zero when disabled", v, 0);
    wrReg(5'h04, 2);
    rdReg(5'h04, v); chk("R8 duty write while disabled", v, 2);
    wrReg(5'h0C, 7);
    rdReg(5'h0C, v); chk("R10 counter write ignored", v, 0);
    repeat (8) @(negedge clk);
    chk("R9 no irq while disabled", int'(irq), 0);
    @(negedge clk) chanEn = 1'b1;
    measure(len, hi);
    chk("R6 period kept after re-enable", len, 5);
    chk("R6 duty kept after re-enable", hi, 2);

    // external clock A, clock B pulses ignored (R2)
    setup(32'hB, 9, 3);
    @(negedge clk) chanEn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) extATick = 1'b1;
      @(negedge clk) extATick = 1'b0; extBTick = 1'b1;
      @(negedge clk) extBTick = 1'b0;
    end
    rdReg(5'h0C, v); chk("R2 external clock A counts", v, 3);

    // external clock B (R2)
    setup(32'hC, 9, 3);
    @(negedge clk) chanEn = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk) extBTick = 1'b1;
      @(negedge clk) extBTick = 1'b0; extATick = 1'b1;
      @(negedge clk) extATick = 1'b0;
    end
    rdReg(5'h0C, v); chk("R2 external clock B counts", v, 2);

    // reserved selection never counts (R2)
    setup(32'hD, 9, 3);
    @(negedge clk) chanEn = 1'b1;
    @(negedge clk) extATick = 1'b1; extBTick = 1'b1;
    @(negedge clk) extATick = 1'b0; extBTick = 1'b0;
    repeat (5) @(negedge clk);
    rdReg(5'h0C, v); chk("R2 reserved selection halts", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule